// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a small in-order integer core with five stages: fetch, register read, execute, data memory and writeback. It runs four instructions: a three-register add, a branch taken when a register is zero whose target comes from a second register, a load and a store. Instruction and data memory are small internal arrays. Both are filled through write ports while reset is held. After reset is released the core runs from address 0. A pair of peek ports exposes any register and any data word, and a retire strobe carrying the PC marks every instruction that leaves the last stage.

Data hazards are resolved by an interlock. While an instruction in register read depends on a register that an older instruction in execute or memory will write, fetch and register read hold and a bubble enters execute. The register file writes before it reads, so a producer in writeback needs no stall. A taken branch resolves in register read. It loads the PC from its target register and discards the single instruction fetched behind it.

Top module: `mini5_core`

## Requirements
- R1: While reset is high, and in the cycle after it falls, retire_valid stays low. The first instruction, at PC 0, retires on the fourth rising edge after reset is released.
- R2: The instruction word is laid out as opcode in bits 31:30 (00 add, 01 branch-if-zero, 10 load, 11 store), then ra in bits 29:25, rb in bits 24:20, rc in bits 19:15 and a signed 15-bit offset in bits 14:0.
- R3: An add writes ra+rb into rc. Register 0 reads as zero, and writes to it are dropped.
- R4: A load writes rc with the data word at byte address ra+offset, indexed by address bits [7:2] with the default size. A store writes rb to that word and changes no register.
- R5: A branch-if-zero sets the next PC to the value of rb when ra is zero. Otherwise it falls through to PC+4, and the next instruction retires one cycle after it.
- R6: On a taken branch the one instruction fetched behind it never retires and has no effect. The target retires two cycles after the branch.
- R7: When a consumer sits d instructions after a producer that writes one of its sources (add ra or rb, load base, store base or data), it retires d+max(0,3-d) cycles after the producer and sees the new value.
- R8: A consumer three instructions behind its producer needs no stall, because a register written in writeback is visible to a read in the same cycle.
- R9: Without hazards or taken branches, one instruction retires every cycle. The retire PCs follow the architectural program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Instruction-memory load strobe |
| imem_waddr | input | 6 | Instruction word index to load |
| imem_wdata | input | 32 | Instruction word to load |
| dmem_we | input | 1 | Data-memory load strobe (wins over a store) |
| dmem_waddr | input | 6 | Data word index to load |
| dmem_wdata | input | 32 | Data word to load |
| reg_peek_addr | input | 5 | Register to observe |
| reg_peek_data | output | 32 | Value of the observed register |
| mem_peek_addr | input | 6 | Data word index to observe |
| mem_peek_data | output | 32 | Value of the observed data word |
| retire_valid | output | 1 | One pulse per retiring instruction |
| retire_pc | output | 32 | PC of the retiring instruction |

## Verification
The hardest situations to reach from the ports are the interlock window at every distance and source slot, and a taken branch whose wrong-path neighbour would write a register. The bench runs a sweep over producer kind (add or load), consumer slot (both add sources, load base, store data, store base) and distance 1 to 4. Each case is a fresh program, and the bench measures the retire-cycle gap and the delivered value. A counted loop then places an add to a guard register right after a backward branch, which makes the squash visible through the register peek.

// File: rtl/mini5_pkg.sv
package mini5_pkg;
    localparam int XLEN  = 32;
    localparam int RA_W  = 5;
    localparam int NREG  = 1 << RA_W;
    localparam int IMM_W = 15;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_BEZ = 2'b01,
        OP_LD  = 2'b10,
        OP_ST  = 2'b11
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [RA_W-1:0]  ra;
        logic [RA_W-1:0]  rb;
        logic [RA_W-1:0]  rc;
        logic [IMM_W-1:0] imm;
    } insn_t;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] pc;
        insn_t           insn;
    } fd_t;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] pc;
        op_e             op;
        logic [RA_W-1:0] rd;
        logic            wr;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic [XLEN-1:0] imm;
    } de_t;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] pc;
        op_e             op;
        logic [RA_W-1:0] rd;
        logic            wr;
        logic [XLEN-1:0] res;
        logic [XLEN-1:0] sdata;
    } em_t;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] pc;
        logic [RA_W-1:0] rd;
        logic            wr;
        logic [XLEN-1:0] res;
    } mw_t;

    function automatic logic op_writes(op_e op);
        return (op == OP_ADD) || (op == OP_LD);
    endfunction

    function automatic logic op_uses_rb(op_e op);
        return op != OP_LD;
    endfunction

    function automatic logic [XLEN-1:0] sext_imm(logic [IMM_W-1:0] imm);
        return {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    endfunction
endpackage

// File: rtl/mini5_ram.sv
module mini5_ram #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 32,
    parameter int N_RD  = 1,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr [N_RD],
    output logic [WIDTH-1:0] rdata [N_RD]
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    for (genvar i = 0; i < N_RD; i++) begin : g_rd
        assign rdata[i] = mem[raddr[i]];
    end
endmodule

// File: rtl/mini5_regfile.sv
module mini5_regfile
    import mini5_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [RA_W-1:0] waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [RA_W-1:0] raddr [3],
    output logic [XLEN-1:0] rdata [3]
);
    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (we && waddr != '0) regs[waddr] <= wdata;
    end

    // write-first: a same-cycle write is visible to every read port
    for (genvar i = 0; i < 3; i++) begin : g_rp
        always_comb begin
            if (raddr[i] == '0)                rdata[i] = '0;
            else if (we && waddr == raddr[i])  rdata[i] = wdata;
            else                               rdata[i] = regs[raddr[i]];
        end
    end

    // R3
    zero_reg_write_chk: assert property (@(posedge clk) disable iff (rst)
        we |-> waddr != '0);
endmodule

// File: rtl/mini5_hazard.sv
module mini5_hazard
    import mini5_pkg::*;
(
    input  logic            fd_valid,
    input  op_e             fd_op,
    input  logic [RA_W-1:0] fd_ra,
    input  logic [RA_W-1:0] fd_rb,
    input  logic            de_valid,
    input  logic            de_wr,
    input  logic [RA_W-1:0] de_rd,
    input  logic            em_valid,
    input  logic            em_wr,
    input  logic [RA_W-1:0] em_rd,
    output logic            stall
);
    function automatic logic pending(logic [RA_W-1:0] src,
                                     logic v1, logic w1, logic [RA_W-1:0] d1,
                                     logic v2, logic w2, logic [RA_W-1:0] d2);
        return (src != '0) && ((v1 && w1 && d1 == src) || (v2 && w2 && d2 == src));
    endfunction

    logic hit_a, hit_b;

    always_comb begin
        hit_a = pending(fd_ra, de_valid, de_wr, de_rd, em_valid, em_wr, em_rd);
        hit_b = op_uses_rb(fd_op) &&
                pending(fd_rb, de_valid, de_wr, de_rd, em_valid, em_wr, em_rd);
        stall = fd_valid && (hit_a || hit_b);
    end
endmodule

// File: rtl/mini5_core.sv
module mini5_core
    import mini5_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IA_W = $clog2(IMEM_WORDS),
    localparam int DA_W = $clog2(DMEM_WORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            imem_we,
    input  logic [IA_W-1:0] imem_waddr,
    input  logic [31:0]     imem_wdata,
    input  logic            dmem_we,
    input  logic [DA_W-1:0] dmem_waddr,
    input  logic [31:0]     dmem_wdata,
    input  logic [4:0]      reg_peek_addr,
    output logic [31:0]     reg_peek_data,
    input  logic [DA_W-1:0] mem_peek_addr,
    output logic [31:0]     mem_peek_data,
    output logic            retire_valid,
    output logic [31:0]     retire_pc
);
    logic [XLEN-1:0] pc_q;
    fd_t fd_q, fd_next;
    de_t de_q, de_next;
    em_t em_q, em_next;
    mw_t mw_q, mw_next;

    logic            stall, taken;
    logic [XLEN-1:0] ra_val, rb_val;

    // ---------------- fetch ----------------
    logic [IA_W-1:0] im_ra [1];
    logic [31:0]     im_rd [1];

    assign im_ra[0] = pc_q[IA_W+1:2];

    mini5_ram #(.DEPTH(IMEM_WORDS), .WIDTH(32), .N_RD(1)) imem_i (
        .clk  (clk),
        .we   (imem_we),
        .waddr(imem_waddr),
        .wdata(imem_wdata),
        .raddr(im_ra),
        .rdata(im_rd)
    );

    always_comb begin
        fd_next.valid = 1'b1;
        fd_next.pc    = pc_q;
        fd_next.insn  = insn_t'(im_rd[0]);
    end

    // ---------------- register read ----------------
    logic [RA_W-1:0] rf_ra [3];
    logic [XLEN-1:0] rf_rd [3];

    assign rf_ra[0] = fd_q.insn.ra;
    assign rf_ra[1] = fd_q.insn.rb;
    assign rf_ra[2] = reg_peek_addr;

    mini5_regfile rf_i (
        .clk  (clk),
        .rst  (rst),
        .we   (mw_q.valid && mw_q.wr),
        .waddr(mw_q.rd),
        .wdata(mw_q.res),
        .raddr(rf_ra),
        .rdata(rf_rd)
    );

    assign ra_val        = rf_rd[0];
    assign rb_val        = rf_rd[1];
    assign reg_peek_data = rf_rd[2];

    mini5_hazard hz_i (
        .fd_valid(fd_q.valid),
        .fd_op   (fd_q.insn.op),
        .fd_ra   (fd_q.insn.ra),
        .fd_rb   (fd_q.insn.rb),
        .de_valid(de_q.valid),
        .de_wr   (de_q.wr),
        .de_rd   (de_q.rd),
        .em_valid(em_q.valid),
        .em_wr   (em_q.wr),
        .em_rd   (em_q.rd),
        .stall   (stall)
    );

    assign taken = fd_q.valid && !stall && fd_q.insn.op == OP_BEZ && ra_val == '0;

    always_comb begin
        de_next.valid = fd_q.valid;
        de_next.pc    = fd_q.pc;
        de_next.op    = fd_q.insn.op;
        de_next.rd    = fd_q.insn.rc;
        de_next.wr    = op_writes(fd_q.insn.op) && fd_q.insn.rc != '0;
        de_next.a     = ra_val;
        de_next.b     = rb_val;
        de_next.imm   = sext_imm(fd_q.insn.imm);
    end

    // ---------------- execute ----------------
    always_comb begin
        em_next.valid = de_q.valid;
        em_next.pc    = de_q.pc;
        em_next.op    = de_q.op;
        em_next.rd    = de_q.rd;
        em_next.wr    = de_q.wr;
        em_next.res   = (de_q.op == OP_ADD) ? de_q.a + de_q.b : de_q.a + de_q.imm;
        em_next.sdata = de_q.b;
    end

    // ---------------- data memory ----------------
    logic            st_go;
    logic [DA_W-1:0] dm_ra [2];
    logic [31:0]     dm_rd [2];

    assign st_go    = em_q.valid && em_q.op == OP_ST;
    assign dm_ra[0] = em_q.res[DA_W+1:2];
    assign dm_ra[1] = mem_peek_addr;

    mini5_ram #(.DEPTH(DMEM_WORDS), .WIDTH(32), .N_RD(2)) dmem_i (
        .clk  (clk),
        .we   (dmem_we || st_go),
        .waddr(dmem_we ? dmem_waddr : em_q.res[DA_W+1:2]),
        .wdata(dmem_we ? dmem_wdata : em_q.sdata),
        .raddr(dm_ra),
        .rdata(dm_rd)
    );

    assign mem_peek_data = dm_rd[1];

    always_comb begin
        mw_next.valid = em_q.valid;
        mw_next.pc    = em_q.pc;
        mw_next.rd    = em_q.rd;
        mw_next.wr    = em_q.wr;
        mw_next.res   = (em_q.op == OP_LD) ? dm_rd[0] : em_q.res;
    end

    // ---------------- writeback / retire ----------------
    assign retire_valid = mw_q.valid;
    assign retire_pc    = mw_q.pc;

    logic unused_bits;
    assign unused_bits = ^{pc_q[XLEN-1:IA_W+2], pc_q[1:0],
                           em_q.res[XLEN-1:DA_W+2], em_q.res[1:0]};

    // ---------------- pipeline registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            fd_q <= '0;
            de_q <= '0;
            em_q <= '0;
            mw_q <= '0;
        end else begin
            if (!stall) begin
                if (taken) begin
                    pc_q       <= rb_val;
                    fd_q.valid <= 1'b0;
                end else begin
                    pc_q <= pc_q + XLEN'(4);
                    fd_q <= fd_next;
                end
            end
            de_q <= stall ? '0 : de_next;
            em_q <= em_next;
            mw_q <= mw_next;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !retire_valid);
    // R6
    wrong_path_squash_chk: assert property (@(posedge clk) disable iff (rst)
        taken |=> !fd_q.valid);
    // R7
    bubble_insert_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> !de_q.valid);
    // R7
    fetch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(pc_q) && $stable(fd_q)));
endmodule

// File: tb/mini5_core_tb.sv
module mini5_core_tb_top;
    localparam int IA_W = 6;
    localparam int DA_W = 6;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            imem_we = 1'b0;
    logic [IA_W-1:0] imem_waddr = '0;
    logic [31:0]     imem_wdata = '0;
    logic            dmem_we = 1'b0;
    logic [DA_W-1:0] dmem_waddr = '0;
    logic [31:0]     dmem_wdata = '0;
    logic [4:0]      reg_peek_addr = '0;
    logic [31:0]     reg_peek_data;
    logic [DA_W-1:0] mem_peek_addr = '0;
    logic [31:0]     mem_peek_data;
    logic            retire_valid;
    logic [31:0]     retire_pc;

    always #10 clk = ~clk;

    mini5_core dut_i (
        .clk(clk), .rst(rst),
        .imem_we(imem_we), .imem_waddr(imem_waddr), .imem_wdata(imem_wdata),
        .dmem_we(dmem_we), .dmem_waddr(dmem_waddr), .dmem_wdata(dmem_wdata),
        .reg_peek_addr(reg_peek_addr), .reg_peek_data(reg_peek_data),
        .mem_peek_addr(mem_peek_addr), .mem_peek_data(mem_peek_data),
        .retire_valid(retire_valid), .retire_pc(retire_pc)
    );

    int ncomp = 0;
    int nerr  = 0;
    bit done  = 1'b0;

    logic [31:0] prog    [64];
    logic [31:0] dm_init [64];
    logic [31:0] iss_reg [32];
    logic [31:0] iss_mem [64];
    logic [31:0] exp_pc  [256];
    logic [31:0] tr_pc   [256];
    int          tr_cyc  [256];
    int          nret = 0;
    int          cyc  = 0;
    int          tot  = 0;

    // R2 field layout
    function automatic logic [31:0] enc(input logic [1:0] op, input int ra, input int rb,
                                        input int rc, input int imm);
        return {op, 5'(ra), 5'(rb), 5'(rc), 15'(imm)};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        ncomp++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= rst ? 0 : cyc + 1;
        tot <= tot + 1;
        if (tot == 150000 && !done) begin
            ncomp++; nerr++;
            $display("FAIL watchdog: actual %0d expected %0d", tot, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncomp, nerr);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (!rst && retire_valid && nret < 256) begin
            tr_pc[nret]  = retire_pc;
            tr_cyc[nret] = cyc;
            nret++;
        end
    end

    task automatic start_run(input int ncyc);
        rst = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 64; i++) begin
            imem_we = 1'b1; imem_waddr = IA_W'(i); imem_wdata = prog[i];
            dmem_we = 1'b1; dmem_waddr = DA_W'(i); dmem_wdata = dm_init[i];
            @(negedge clk);
            // R1 quiet while held in reset
            if (i == 63) chk("R1", "retire during reset", int'(retire_valid), 0);
        end
        imem_we = 1'b0; dmem_we = 1'b0;
        nret = 0;
        rst = 1'b0;
        repeat (ncyc) @(negedge clk);
    endtask

    function automatic int peek_reg_dummy(input int r);
        return r;
    endfunction

    task automatic get_reg(input int r, output int v);
        reg_peek_addr = 5'(r); #1; v = int'(reg_peek_data);
    endtask

    task automatic get_mem(input int a, output int v);
        mem_peek_addr = DA_W'(a); #1; v = int'(mem_peek_data);
    endtask

    // architectural model used for expected trace and final state
    task automatic iss(input int steps);
        logic [31:0] p, w, ea;
        int ra, rb, rc;
        for (int i = 0; i < 32; i++) iss_reg[i] = '0;
        for (int i = 0; i < 64; i++) iss_mem[i] = dm_init[i];
        p = '0;
        for (int k = 0; k < steps; k++) begin
            exp_pc[k] = p;
            w  = prog[p[7:2]];
            ra = int'(w[29:25]); rb = int'(w[24:20]); rc = int'(w[19:15]);
            ea = iss_reg[ra] + {{17{w[14]}}, w[14:0]};
            case (w[31:30])
                2'b00: begin if (rc != 0) iss_reg[rc] = iss_reg[ra] + iss_reg[rb]; p = p + 4; end
                2'b01: p = (iss_reg[ra] == 0) ? iss_reg[rb] : p + 4;
                2'b10: begin if (rc != 0) iss_reg[rc] = iss_mem[ea[7:2]]; p = p + 4; end
                default: begin iss_mem[ea[7:2]] = iss_reg[rb]; p = p + 4; end
            endcase
        end
    endtask

    initial begin
        int v, g, k;
        repeat (3) @(negedge clk);

        // ---------- counted loop program ----------
        for (int i = 0; i < 64; i++) begin prog[i] = enc(2'b01, 0, 14, 0, 0); dm_init[i] = '0; end
        dm_init[0] = 5; dm_init[1] = 32'hFFFF_FFFF;
        dm_init[2] = 3; dm_init[3] = 7; dm_init[4] = 11; dm_init[5] = 20; dm_init[6] = 100;
        dm_init[7] = 8; dm_init[8] = 36; dm_init[9] = 64; dm_init[10] = 4;
        dm_init[12] = 99; dm_init[13] = 80; dm_init[14] = 0;
        prog[0]  = enc(2'b10, 0, 0, 1, 0);
        prog[1]  = enc(2'b10, 0, 0, 2, 4);
        prog[2]  = enc(2'b10, 0, 0, 4, 28);
        prog[3]  = enc(2'b10, 0, 0, 5, 32);
        prog[4]  = enc(2'b10, 0, 0, 6, 36);
        prog[5]  = enc(2'b10, 0, 0, 7, 40);
        prog[6]  = enc(2'b10, 0, 0, 14, 52);
        prog[7]  = enc(2'b10, 0, 0, 10, 56);
        prog[8]  = enc(2'b00, 0, 0, 8, 0);
        prog[9]  = enc(2'b01, 1, 6, 0, 0);
        prog[10] = enc(2'b10, 4, 0, 9, 0);
        prog[11] = enc(2'b00, 8, 9, 8, 0);
        prog[12] = enc(2'b00, 4, 7, 4, 0);
        prog[13] = enc(2'b00, 1, 2, 1, 0);
        prog[14] = enc(2'b01, 0, 5, 0, 0);
        prog[15] = enc(2'b00, 2, 2, 10, 0);
        prog[16] = enc(2'b11, 0, 8, 0, 44);
        prog[17] = enc(2'b11, 0, 1, 0, 48);
        prog[18] = enc(2'b10, 0, 0, 11, 44);
        prog[19] = enc(2'b00, 11, 11, 12, 0);
        prog[20] = enc(2'b01, 0, 14, 0, 0);
        start_run(400);
        iss(60);

        // R1 first retire timing
        chk("R1", "first retire cycle", tr_cyc[0], 4);
        chk("R1", "first retire pc", int'(tr_pc[0]), 0);
        // R9 throughput over the independent prologue
        for (int i = 1; i < 9; i++) chk("R9", "prologue retire gap", tr_cyc[i] - tr_cyc[i-1], 1);
        // R9 program-order trace
        chk("R9", "trace length", (nret >= 60) ? 1 : 0, 1);
        for (int i = 0; i < 60; i++) chk("R9", "retire pc", int'(tr_pc[i]), int'(exp_pc[i]));
        // R3 R4 final state
        foreach (iss_reg[r]) if (r inside {1, 2, 4, 8, 9, 11, 12}) begin
            get_reg(r, v); chk("R3", $sformatf("reg %0d", r), v, int'(iss_reg[r]));
        end
        get_reg(8, v);  chk("R4", "loop sum", v, 141);
        get_reg(12, v); chk("R3", "doubled sum", v, 282);
        get_reg(0, v);  chk("R3", "r0 reads zero", v, 0);
        get_mem(11, v); chk("R4", "stored sum", v, int'(iss_mem[11]));
        get_mem(12, v); chk("R4", "stored counter", v, 0);
        // R6 squashed wrong-path add never wrote its guard register
        get_reg(10, v); chk("R6", "wrong-path guard", v, 0);
        // R6 taken gap and R5 fall-through gap
        g = -1;
        for (k = 0; k < 59; k++) if (tr_pc[k] == 56 && g < 0) g = k;
        chk("R6", "target after backward branch", int'(tr_pc[g+1]), 36);
        chk("R6", "taken branch gap", tr_cyc[g+1] - tr_cyc[g], 2);
        g = -1;
        for (k = 0; k < 59; k++) if (tr_pc[k] == 36 && tr_pc[k+1] == 40 && g < 0) g = k;
        chk("R5", "not-taken gap", tr_cyc[g+1] - tr_cyc[g], 1);

        // ---------- interlock sweep ----------
        for (int pt = 0; pt < 2; pt++)
            for (int ct = 0; ct < 5; ct++)
                for (int d = 1; d <= 4; d++) begin
                    int hidx, egap;
                    hidx = 4 + d + 1;
                    for (int i = 0; i < 64; i++) begin prog[i] = enc(2'b01, 0, 26, 0, 0); dm_init[i] = '0; end
                    dm_init[0] = 8; dm_init[1] = 4; dm_init[2] = 77; dm_init[5] = hidx * 4;
                    prog[0] = enc(2'b10, 0, 0, 22, 4);
                    prog[1] = enc(2'b10, 0, 0, 26, 20);
                    prog[2] = enc(2'b00, 0, 0, 24, 0);
                    prog[3] = enc(2'b00, 0, 0, 0, 0);
                    prog[4] = (pt == 0) ? enc(2'b00, 22, 22, 20, 0) : enc(2'b10, 0, 0, 20, 0);
                    for (int f = 1; f < d; f++) prog[4+f] = enc(2'b00, 22, 22, 21, 0);
                    case (ct)
                        0: prog[4+d] = enc(2'b00, 20, 22, 24, 0);
                        1: prog[4+d] = enc(2'b00, 22, 20, 24, 0);
                        2: prog[4+d] = enc(2'b10, 20, 0, 24, 0);
                        3: prog[4+d] = enc(2'b11, 0, 20, 0, 60);
                        default: prog[4+d] = enc(2'b11, 20, 22, 0, 4);
                    endcase
                    start_run(40);
                    egap = d + ((d < 3) ? 3 - d : 0);
                    chk(d == 3 ? "R8" : "R7", $sformatf("gap pt%0d ct%0d d%0d", pt, ct, d),
                        tr_cyc[4+d] - tr_cyc[4], egap);
                    chk("R7", "consumer pc", int'(tr_pc[4+d]), (4 + d) * 4);
                    case (ct)
                        0, 1: begin get_reg(24, v); chk("R7", "add result", v, 12); end
                        2:    begin get_reg(24, v); chk("R7", "load result", v, 77); end
                        3:    begin get_mem(15, v); chk("R7", "store data", v, 8); end
                        default: begin get_mem(3, v); chk("R7", "store base", v, 4); end
                    endcase
                end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncomp, nerr);
        $finish;
    end
endmodule